// File: doc/BRIEF.md
# Key-Unlocked Configuration Port

This block is a host-visible configuration port that uses an index/data register pair. The index register sits at a base I/O address and the data register at the next address. The port starts out locked. While it is locked, the only index write that has any effect is the unlock key. After the key has been written, the index register holds the last value written to it and returns that value on a read. Host software can use this readback to find out whether a port is present at a given address.

While the port is unlocked, the data register gives access to a small configuration space. That space contains a logical-device selector, a fixed identification byte and a revision byte. It also contains three registers that are banked per logical device: an activate bit, and the high and low bytes of a 16-bit I/O base address. One logical device is the mailbox. Its base address, the data address that follows it, and its activate bit are exported as outputs, so that other logic can decode the mailbox window.

The host side is a simple strobe interface with one-cycle write and read pulses. Read data is registered: it appears in the cycle after the read pulse and holds until the next read.

Top module: `scp_cfg_port`

## Requirements
- R1: A write of 0x55 to the index address (BASE_ADDR) while locked unlocks the port. A write of 0xAA to the index address while unlocked locks it. Any other index write while locked leaves the port locked.
- R2: While unlocked, a read of the index address returns the last index value written while unlocked. While locked, such a read returns 0xFF.
- R3: While locked, a read of the data address (BASE_ADDR+1) returns 0xFF. While locked, a write to the data address changes no configuration state.
- R4: Index 0x07 selects the logical device number; a read of it returns the 8-bit value written.
- R5: Index 0x20 reads DEVICE_ID and index 0x21 reads REVISION; writes to them are ignored.
- R6: Index 0x30 holds the activate flag of the selected device in bit 0; a read returns that flag in bit 0 with bits 7:1 as zero.
- R7: Index 0x60 holds the high byte and index 0x61 the low byte of the selected device's 16-bit base address. Each device keeps its own copy.
- R8: `mbx_base` and `mbx_active` show the base address and activate flag of device MBX_LDEV. `mbx_data_addr` equals `mbx_base` + 1.
- R9: After reset the port is locked, device 0 is selected, every activate flag is clear, device MBX_LDEV has base MBX_RST_BASE, every other device has base 0, and `io_rdata` is 0xFF.
- R10: A second 0x55 written while already unlocked keeps the port unlocked and is stored as the index value, so the index reads 0x55.
- R11: `io_rdata` updates only in the cycle after an `io_rd` pulse and otherwise holds. A read of any address other than the two port addresses returns 0xFF. An unimplemented index, or a banked index while a device number of NUM_LDEV or above is selected, reads 0x00 and ignores writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| io_addr | input | 16 | Host I/O address |
| io_wr | input | 1 | One-cycle write strobe |
| io_rd | input | 1 | One-cycle read strobe |
| io_wdata | input | 8 | Write data |
| io_rdata | output | 8 | Registered read data |
| mbx_base | output | 16 | Base address of the mailbox device |
| mbx_data_addr | output | 16 | Mailbox data address (base + 1) |
| mbx_active | output | 1 | Activate flag of the mailbox device |

## Verification
The bench first probes the port while it is locked, using both a non-key value and the lock key. It checks that these writes leave the index readback at 0xFF, and that 0x55 alone makes the readback follow the written value. Banked accesses are interleaved across devices 3 and 9. A value written to one device must therefore come back only from that device, which separates a correct bank select from a single shared register. Writes made while locked, and writes made while an out-of-range device is selected, are each followed by readback through the unlocked port and by a look at the mailbox outputs. This shows that those writes were dropped rather than applied to some other device.

// File: rtl/scp_pkg.sv
package scp_pkg;
    localparam logic [7:0] KEY_OPEN    = 8'h55;
    localparam logic [7:0] KEY_CLOSE   = 8'hAA;
    localparam logic [7:0] IDX_LDSEL   = 8'h07;
    localparam logic [7:0] IDX_DEVID   = 8'h20;
    localparam logic [7:0] IDX_REV     = 8'h21;
    localparam logic [7:0] IDX_ACT     = 8'h30;
    localparam logic [7:0] IDX_BASE_HI = 8'h60;
    localparam logic [7:0] IDX_BASE_LO = 8'h61;
    localparam logic [7:0] RD_IDLE     = 8'hFF;

    typedef struct packed {
        logic        open;
        logic [7:0]  idx;
    } key_state_t;

    typedef struct packed {
        logic        active;
        logic [15:0] base;
    } ldev_regs_t;

    typedef struct packed {
        logic [7:0]  ldn;
        logic [7:0]  rdata;
    } port_state_t;
endpackage

// File: rtl/scp_unlock.sv
module scp_unlock
    import scp_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       idx_wr,
    input  logic [7:0] wdata,
    output logic       unlocked,
    output logic [7:0] index
);
    key_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (idx_wr) begin
            if (!st_q.open) begin
                if (wdata == KEY_OPEN) st_d.open = 1'b1;
            end else if (wdata == KEY_CLOSE) begin
                st_d.open = 1'b0;
            end else begin
                st_d.idx = wdata;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign unlocked = st_q.open;
    assign index    = st_q.idx;
endmodule

// File: rtl/scp_ldev_bank.sv
module scp_ldev_bank
    import scp_pkg::*;
#(
    parameter int          NUM_LDEV     = 12,
    parameter int          MBX_LDEV     = 9,
    parameter logic [15:0] MBX_RST_BASE = 16'h0A00
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic [7:0]  sel,
    input  logic [7:0]  reg_idx,
    input  logic [7:0]  wdata,
    output logic [7:0]  rd_val,
    output logic [15:0] mbx_base,
    output logic        mbx_active
);
    ldev_regs_t regs [NUM_LDEV];

    for (genvar g = 0; g < NUM_LDEV; g++) begin : g_dev
        localparam logic [15:0] RST_BASE = (g == MBX_LDEV) ? MBX_RST_BASE : 16'h0000;
        ldev_regs_t r_d, r_q;

        always_comb begin
            r_d = r_q;
            if (wr_en && sel == 8'(g)) begin
                case (reg_idx)
                    IDX_ACT:     r_d.active     = wdata[0];
                    IDX_BASE_HI: r_d.base[15:8] = wdata;
                    IDX_BASE_LO: r_d.base[7:0]  = wdata;
                    default: ;
                endcase
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) r_q <= '{active: 1'b0, base: RST_BASE};
            else        r_q <= r_d;
        end

        assign regs[g] = r_q;
    end

    always_comb begin
        rd_val = 8'h00;
        for (int i = 0; i < NUM_LDEV; i++) begin
            if (sel == 8'(i)) begin
                case (reg_idx)
                    IDX_ACT:     rd_val = {7'b0, regs[i].active};
                    IDX_BASE_HI: rd_val = regs[i].base[15:8];
                    IDX_BASE_LO: rd_val = regs[i].base[7:0];
                    default:     rd_val = 8'h00;
                endcase
            end
        end
    end

    assign mbx_base   = regs[MBX_LDEV].base;
    assign mbx_active = regs[MBX_LDEV].active;
endmodule

// File: rtl/scp_cfg_port.sv
module scp_cfg_port
    import scp_pkg::*;
#(
    parameter logic [15:0] BASE_ADDR    = 16'h002E,
    parameter logic [7:0]  DEVICE_ID    = 8'h5A,
    parameter logic [7:0]  REVISION     = 8'h03,
    parameter int          NUM_LDEV     = 12,
    parameter int          MBX_LDEV     = 9,
    parameter logic [15:0] MBX_RST_BASE = 16'h0A00
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [15:0] io_addr,
    input  logic        io_wr,
    input  logic        io_rd,
    input  logic [7:0]  io_wdata,
    output logic [7:0]  io_rdata,
    output logic [15:0] mbx_base,
    output logic [15:0] mbx_data_addr,
    output logic        mbx_active
);
    localparam logic [15:0] DATA_ADDR = BASE_ADDR + 16'd1;

    logic        hit_idx, hit_dat;
    logic        cfg_open;
    logic [7:0]  cfg_idx;
    logic [7:0]  bank_rd;
    logic        bank_wr;
    logic [7:0]  rd_mux;
    port_state_t ps_d, ps_q;

    assign hit_idx = (io_addr == BASE_ADDR);
    assign hit_dat = (io_addr == DATA_ADDR);
    assign bank_wr = io_wr && hit_dat && cfg_open;

    scp_unlock u_unlock (
        .clk      (clk),
        .rst_n    (rst_n),
        .idx_wr   (io_wr && hit_idx),
        .wdata    (io_wdata),
        .unlocked (cfg_open),
        .index    (cfg_idx)
    );

    scp_ldev_bank #(
        .NUM_LDEV     (NUM_LDEV),
        .MBX_LDEV     (MBX_LDEV),
        .MBX_RST_BASE (MBX_RST_BASE)
    ) u_bank (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (bank_wr),
        .sel        (ps_q.ldn),
        .reg_idx    (cfg_idx),
        .wdata      (io_wdata),
        .rd_val     (bank_rd),
        .mbx_base   (mbx_base),
        .mbx_active (mbx_active)
    );

    always_comb begin
        rd_mux = RD_IDLE;
        if (hit_idx) begin
            rd_mux = cfg_open ? cfg_idx : RD_IDLE;
        end else if (hit_dat && cfg_open) begin
            case (cfg_idx)
                IDX_LDSEL: rd_mux = ps_q.ldn;
                IDX_DEVID: rd_mux = DEVICE_ID;
                IDX_REV:   rd_mux = REVISION;
                default:   rd_mux = bank_rd;
            endcase
        end
    end

    always_comb begin
        ps_d = ps_q;
        if (bank_wr && cfg_idx == IDX_LDSEL) ps_d.ldn = io_wdata;
        if (io_rd) ps_d.rdata = rd_mux;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ps_q <= '{ldn: 8'h00, rdata: RD_IDLE};
        else        ps_q <= ps_d;
    end

    assign io_rdata      = ps_q.rdata;
    assign mbx_data_addr = mbx_base + 16'd1;
endmodule

// File: rtl/scp_cfg_port_chk.sv
module scp_cfg_port_chk #(
    parameter logic [15:0] BASE_ADDR = 16'h002E,
    parameter logic [7:0]  DEVICE_ID = 8'h5A
) (
    input logic        clk,
    input logic        rst_n,
    input logic [15:0] io_addr,
    input logic        io_wr,
    input logic        io_rd,
    input logic [7:0]  io_wdata,
    input logic [7:0]  io_rdata,
    input logic [15:0] mbx_base,
    input logic        mbx_active,
    input logic        cfg_open,
    input logic [7:0]  cfg_idx
);
    logic at_idx, at_dat;
    assign at_idx = (io_addr == BASE_ADDR);
    assign at_dat = (io_addr == BASE_ADDR + 16'd1);

    a_r1_unlock: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_open && io_wr && at_idx && io_wdata == 8'h55) |=> cfg_open);

    a_r1_lock: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_open && io_wr && at_idx && io_wdata == 8'hAA) |=> !cfg_open);

    a_r2_locked_index_ff: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_open && io_rd && at_idx) |=> io_rdata == 8'hFF);

    a_r3_locked_write_dropped: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_open && io_wr && at_dat) |=> ($stable(mbx_base) && $stable(mbx_active)));

    a_r5_device_id: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_open && io_rd && !io_wr && at_dat && cfg_idx == 8'h20) |=> io_rdata == DEVICE_ID);

    a_r11_rdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !io_rd |=> $stable(io_rdata));
endmodule

bind scp_cfg_port scp_cfg_port_chk #(
    .BASE_ADDR (BASE_ADDR),
    .DEVICE_ID (DEVICE_ID)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .io_addr    (io_addr),
    .io_wr      (io_wr),
    .io_rd      (io_rd),
    .io_wdata   (io_wdata),
    .io_rdata   (io_rdata),
    .mbx_base   (mbx_base),
    .mbx_active (mbx_active),
    .cfg_open   (cfg_open),
    .cfg_idx    (cfg_idx)
);

// File: tb/tb_scp_cfg_port.sv
module tb_scp_cfg_port;
    localparam logic [15:0] BASE = 16'h002E;
    localparam logic [15:0] DAT  = 16'h002F;
    localparam logic [7:0]  DEVID = 8'h5A;
    localparam logic [7:0]  REV   = 8'h03;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] io_addr = '0;
    logic        io_wr = 1'b0;
    logic        io_rd = 1'b0;
    logic [7:0]  io_wdata = '0;
    logic [7:0]  io_rdata;
    logic [15:0] mbx_base, mbx_data_addr;
    logic        mbx_active;

    int n_chk = 0;
    int n_bad = 0;
    logic [7:0] rv;

    always #4 clk = ~clk;

    scp_cfg_port dut (
        .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wr(io_wr), .io_rd(io_rd),
        .io_wdata(io_wdata), .io_rdata(io_rdata), .mbx_base(mbx_base),
        .mbx_data_addr(mbx_data_addr), .mbx_active(mbx_active)
    );

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic io_write(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        io_addr = a; io_wdata = d; io_wr = 1'b1;
        @(negedge clk);
        io_wr = 1'b0;
    endtask

    task automatic io_read(input logic [15:0] a, output logic [7:0] d);
        @(negedge clk);
        io_addr = a; io_rd = 1'b1;
        @(negedge clk);
        io_rd = 1'b0;
        d = io_rdata;
    endtask

    task automatic cfg_wr(input logic [7:0] idx, input logic [7:0] d);
        io_write(BASE, idx);
        io_write(DAT, d);
    endtask

    task automatic cfg_rd(input logic [7:0] idx, output logic [7:0] d);
        io_write(BASE, idx);
        io_read(DAT, d);
    endtask

    task automatic t_reset;
        check("R9 rdata after reset", {8'h0, io_rdata}, 16'h00FF);
        check("R9 mbx_base default", mbx_base, 16'h0A00);
        check("R9 mbx_active clear", {15'h0, mbx_active}, 16'h0);
        check("R8 mbx_data_addr default", mbx_data_addr, 16'h0A01);
    endtask

    task automatic t_locked_probe;
        io_write(BASE, 8'h20);
        io_read(BASE, rv);
        check("R2 locked index reads FF", {8'h0, rv}, 16'h00FF);
        io_write(BASE, 8'hAA);
        io_read(DAT, rv);
        check("R3 locked data reads FF", {8'h0, rv}, 16'h00FF);
    endtask

    task automatic t_unlock_ids;
        io_write(BASE, 8'h55);
        io_write(BASE, 8'h20);
        io_read(BASE, rv);
        check("R2 index readback unlocked", {8'h0, rv}, 16'h0020);
        check("R1 unlock via readback", {8'h0, rv}, 16'h0020);
        io_read(DAT, rv);
        check("R5 device id", {8'h0, rv}, {8'h0, DEVID});
        io_write(DAT, 8'h99);
        cfg_rd(8'h21, rv);
        check("R5 revision", {8'h0, rv}, {8'h0, REV});
        io_write(BASE, 8'h55);
        io_read(BASE, rv);
        check("R10 second key stored as index", {8'h0, rv}, 16'h0055);
        io_read(DAT, rv);
        check("R10 still unlocked, index 55 reads 00", {8'h0, rv}, 16'h0000);
    endtask

    task automatic t_banking;
        cfg_wr(8'h07, 8'h03);
        cfg_rd(8'h07, rv);
        check("R4 device select readback", {8'h0, rv}, 16'h0003);
        cfg_wr(8'h30, 8'hFF);
        cfg_rd(8'h30, rv);
        check("R6 activate bit only", {8'h0, rv}, 16'h0001);
        cfg_wr(8'h60, 8'h12);
        cfg_wr(8'h61, 8'h34);
        check("R8 other device leaves mailbox", mbx_base, 16'h0A00);
        cfg_wr(8'h07, 8'h09);
        cfg_rd(8'h60, rv);
        check("R7 mailbox high default", {8'h0, rv}, 16'h000A);
        cfg_rd(8'h30, rv);
        check("R6 activate banked", {8'h0, rv}, 16'h0000);
        cfg_wr(8'h60, 8'h1C);
        cfg_wr(8'h61, 8'h80);
        cfg_wr(8'h30, 8'h01);
        check("R8 mbx_base", mbx_base, 16'h1C80);
        check("R8 mbx_data_addr", mbx_data_addr, 16'h1C81);
        check("R8 mbx_active", {15'h0, mbx_active}, 16'h0001);
        cfg_wr(8'h07, 8'h03);
        cfg_rd(8'h61, rv);
        check("R7 device 3 low byte kept", {8'h0, rv}, 16'h0034);
    endtask

    task automatic t_out_of_range;
        cfg_wr(8'h07, 8'hF0);
        cfg_wr(8'h60, 8'h77);
        cfg_rd(8'h60, rv);
        check("R11 out-of-range device reads 00", {8'h0, rv}, 16'h0000);
        cfg_wr(8'h07, 8'h03);
        cfg_rd(8'h60, rv);
        check("R11 out-of-range write ignored", {8'h0, rv}, 16'h0012);
        check("R11 mailbox untouched", mbx_base, 16'h1C80);
    endtask

    task automatic t_relock;
        cfg_wr(8'h07, 8'h09);
        io_write(BASE, 8'h60);
        io_write(BASE, 8'hAA);
        io_read(BASE, rv);
        check("R1 lock key relocks", {8'h0, rv}, 16'h00FF);
        io_write(DAT, 8'h00);
        check("R3 locked write keeps mbx_base", mbx_base, 16'h1C80);
        io_write(BASE, 8'h07);
        io_write(BASE, 8'hAA);
        io_read(BASE, rv);
        check("R1 non-key stays locked", {8'h0, rv}, 16'h00FF);
        io_write(BASE, 8'h55);
        io_read(DAT, rv);
        check("R3 locked writes dropped", {8'h0, rv}, 16'h001C);
    endtask

    task automatic t_rdata_misc;
        io_read(16'h0100, rv);
        check("R11 unmapped read FF", {8'h0, rv}, 16'h00FF);
        cfg_rd(8'h20, rv);
        repeat (3) @(negedge clk);
        check("R11 rdata holds", {8'h0, io_rdata}, {8'h0, DEVID});
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_locked_probe();
        t_unlock_ids();
        t_banking();
        t_out_of_range();
        t_relock();
        t_rdata_misc();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule